// File: doc/BRIEF.md
# Single-Wire Slave Addressing Controller

This block is the addressing layer of a slave on a shared single-wire bus where many devices hang off one data line. After every bus reset it collects one command byte from decoded bit slots and carries it out against the device's 64-bit identity. The identity is laid out as an 8-bit family code in the low byte, a 48-bit serial number above it, and an 8-bit check code in the top byte. Because the identity is unique, it serves as the node address.

The supported commands are:

- Read the identity out.
- Match it against the master's copy.
- Take part in a bitwise search arbitration.
- Skip addressing.
- Two variants that also switch the bus into a faster overdrive regime.

Only a command that completes successfully raises the flag that hands the bus to the memory-command layer.

An analog front end sits upstream and delivers one pulse per bit slot, together with the sampled line level and a reset-detected strobe. That strobe carries a qualifier which says whether the reset pulse was long enough for standard speed. The controller drives back the bit the front end should present in read slots, the memory-enable flag and the overdrive flag.

Top module: `romfn_ctrl`

## Requirements
- R1: After `rst_n` is released the controller waits for a command byte, with `mem_enable` = 0, `overdrive` = 0 and `tx_bit` = 1 (line released).
- R2: A command byte is taken from 8 consecutive slots, least significant bit first. A byte sent in the reversed bit order is therefore not recognised as the intended command.
- R3: Command 0x33 (read) presents the 64 identity bits on `tx_bit` in the 64 following slots, bit 0 first, each bit valid before its slot. After the last slot `mem_enable` becomes 1.
- R4: Command 0x55 (match) compares 64 received slot bits, bit 0 first, against the identity with `tx_bit` held at 1. If all 64 are equal, `mem_enable` becomes 1. Any difference, including in bit 63, leaves `mem_enable` at 0 until the next bus reset.
- R5: Command 0xF0 (search) runs three slots per identity bit: `tx_bit` shows the bit, then its complement, then 1 while the master's chosen bit is read. If the chosen bit differs from the identity bit the controller drops out and keeps `tx_bit` = 1. After all 64 bits agree, `mem_enable` becomes 1.
- R6: Command 0xCC (skip) sets `mem_enable` to 1 right after the command byte, without touching `overdrive`.
- R7: Command 0x3C (overdrive-skip) sets both `overdrive` and `mem_enable` to 1 right after the command byte.
- R8: Command 0x69 (overdrive-match) sets `overdrive` to 1 right after the command byte, then behaves as a match. The match outcome decides `mem_enable` but does not clear `overdrive`.
- R9: Any other command byte leaves the controller idle until the next bus reset. While idle, `mem_enable` stays 0, `tx_bit` stays 1, and later slots, including a valid command byte, have no effect.
- R10: A `bus_reset` strobe returns the controller to waiting for a command byte and clears `mem_enable`, even in the middle of a transfer. `overdrive` is cleared only when `bus_reset_long` is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid | input | 1 | One-cycle strobe: a bit slot has completed |
| slot_bit | input | 1 | Line level sampled in that slot |
| bus_reset | input | 1 | One-cycle strobe: a bus reset pulse was detected |
| bus_reset_long | input | 1 | Qualifies `bus_reset`: the pulse met standard-speed length |
| device_id | input | ID_W (64) | Device identity, family code in bits 7:0 |
| tx_bit | output | 1 | Level to present in the current slot (1 = release line) |
| mem_enable | output | 1 | Addressing succeeded; memory-command layer may run |
| overdrive | output | 1 | Bus runs at overdrive speed |

## Verification
The assertions assume several things about the inputs:

- `slot_valid` and `bus_reset` are single-cycle strobes that do not arrive in two adjacent cycles.
- `device_id` is stable while the device is addressed.
- `bus_reset_long` is only meaningful alongside `bus_reset`.

The bench keeps within these assumptions. It holds the identity constant, raises each strobe for exactly one cycle, and leaves at least three idle cycles after every slot, so that the registered command byte has been decoded before the next slot arrives. Every read-slot value is predicted from the identity and the requirement under test and queued before the slot is issued.

// File: rtl/romfn_pkg.sv
// Package: command codes and sequencer state type shared by the addressing
// controller and its submodules. Assumes 8-bit command bytes.
package romfn_pkg;

    localparam int CMD_W = 8;

    // Command byte values (received least significant bit first)
    localparam logic [CMD_W-1:0] OP_READ     = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH    = 8'h55;
    localparam logic [CMD_W-1:0] OP_SEARCH   = 8'hF0;
    localparam logic [CMD_W-1:0] OP_SKIP     = 8'hCC;
    localparam logic [CMD_W-1:0] OP_OD_SKIP  = 8'h3C;
    localparam logic [CMD_W-1:0] OP_OD_MATCH = 8'h69;

    typedef enum logic [2:0] {
        ST_CMD    = 3'd0,   // collecting command byte
        ST_READ   = 3'd1,   // emitting identity
        ST_MATCH  = 3'd2,   // comparing identity
        ST_S_TRUE = 3'd3,   // search: send identity bit
        ST_S_CMP  = 3'd4,   // search: send its complement
        ST_S_DIR  = 3'd5,   // search: read master's chosen bit
        ST_SEL    = 3'd6,   // addressed, memory layer enabled
        ST_LOCK   = 3'd7    // dropped out until next bus reset
    } seq_state_e;

endpackage

// File: rtl/romfn_cmd_rx.sv
// Module: command byte deserializer.
// Shifts slot bits in least significant bit first while 'listen' is high and
// raises a one-cycle 'cmd_valid' in the cycle after the last bit, with the
// byte held on 'cmd_byte'. Assumes slot_valid is a one-cycle strobe.
module romfn_cmd_rx #(
    parameter int CMD_W = romfn_pkg::CMD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             listen,
    input  logic             slot_valid,
    input  logic             slot_bit,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_byte
);
    localparam int              CNT_W = (CMD_W > 1) ? $clog2(CMD_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

    logic [CMD_W-1:0] shreg;
    logic [CNT_W-1:0] cnt;

    // Shift in one bit per accepted slot; flag the completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            cmd_valid <= 1'b0;
        end else if (clear) begin
            shreg     <= '0;
            cnt       <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (listen && slot_valid) begin
                shreg <= {slot_bit, shreg[CMD_W-1:1]};
                if (cnt == CNT_LAST) begin
                    cnt       <= '0;
                    cmd_valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign cmd_byte = shreg;

    // R2: a completed byte is flagged for exactly one cycle
    a_r2_byte_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R2: the completing edge consumed a slot while listening
    a_r2_byte_from_slot: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(listen && slot_valid));

endmodule

// File: rtl/romfn_bit_idx.sv
// Module: identity bit index counter.
// Counts 0..N-1 on 'inc', wraps after the last position, 'clr' has priority.
// 'last' flags the final identity bit. Shared by read, match and search.
module romfn_bit_idx #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 inc,
    output logic [$clog2(N)-1:0] idx,
    output logic                 last
);
    localparam int              IW = $clog2(N);
    localparam logic [IW-1:0]   IDX_LAST = IW'(N - 1);

    // Advance or clear the bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (inc) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

    // Final bit position decode.
    always_comb last = (idx == IDX_LAST);

endmodule

// File: rtl/romfn_seq_fsm.sv
// Module: addressing sequencer.
// Decodes the command byte and steps through read, match or search over the
// identity one slot at a time. It owns the overdrive flag and drives the
// transmit level. Assumes bus_reset and slot_valid are one-cycle strobes and
// that id_bit reflects the identity bit at the current index.
module romfn_seq_fsm
    import romfn_pkg::*;
#(
    parameter int CMD_W = romfn_pkg::CMD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             bus_reset_long,
    input  logic             slot_valid,
    input  logic             slot_bit,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             id_bit,
    input  logic             idx_last,
    output logic             idx_clr,
    output logic             idx_inc,
    output logic             listen,
    output logic             tx_bit,
    output logic             mem_enable,
    output logic             overdrive,
    output seq_state_e       state
);
    seq_state_e st, nxt;
    logic       od_set;
    logic       cmd_clr;

    // Next-state and counter control from the current state and slot.
    always_comb begin
        nxt     = st;
        idx_inc = 1'b0;
        cmd_clr = 1'b0;
        od_set  = 1'b0;
        unique case (st)
            ST_CMD: begin
                if (cmd_valid) begin
                    cmd_clr = 1'b1;
                    case (cmd_byte)
                        OP_READ:     nxt = ST_READ;
                        OP_MATCH:    nxt = ST_MATCH;
                        OP_SEARCH:   nxt = ST_S_TRUE;
                        OP_SKIP:     nxt = ST_SEL;
                        OP_OD_SKIP:  begin nxt = ST_SEL;   od_set = 1'b1; end
                        OP_OD_MATCH: begin nxt = ST_MATCH; od_set = 1'b1; end
                        default:     nxt = ST_LOCK;
                    endcase
                end
            end
            ST_READ: begin
                if (slot_valid) begin
                    if (idx_last) nxt = ST_SEL;
                    else          idx_inc = 1'b1;
                end
            end
            ST_MATCH: begin
                if (slot_valid) begin
                    if (slot_bit != id_bit) nxt = ST_LOCK;
                    else if (idx_last)      nxt = ST_SEL;
                    else                    idx_inc = 1'b1;
                end
            end
            ST_S_TRUE: if (slot_valid) nxt = ST_S_CMP;
            ST_S_CMP:  if (slot_valid) nxt = ST_S_DIR;
            ST_S_DIR: begin
                if (slot_valid) begin
                    if (slot_bit != id_bit) nxt = ST_LOCK;
                    else if (idx_last)      nxt = ST_SEL;
                    else begin
                        nxt     = ST_S_TRUE;
                        idx_inc = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // State and overdrive registers; bus reset has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_CMD;
            overdrive <= 1'b0;
        end else if (bus_reset) begin
            st <= ST_CMD;
            if (bus_reset_long) overdrive <= 1'b0;
        end else begin
            st <= nxt;
            if (od_set) overdrive <= 1'b1;
        end
    end

    // Transmit level: identity bit, its complement, or released line.
    always_comb begin
        case (st)
            ST_READ, ST_S_TRUE: tx_bit = id_bit;
            ST_S_CMP:           tx_bit = ~id_bit;
            default:            tx_bit = 1'b1;
        endcase
    end

    // Output decodes from the state register.
    always_comb begin
        idx_clr    = bus_reset | cmd_clr;
        listen     = (st == ST_CMD);
        mem_enable = (st == ST_SEL);
        state      = st;
    end

    // R10: a bus reset always lands in command wait with memory disabled
    a_r10_reset_returns: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (st == ST_CMD) && !mem_enable);

    // R10: overdrive falls only on a standard-length bus reset
    a_r10_od_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overdrive) |-> $past(bus_reset && bus_reset_long));

    // R7, R8: overdrive rises only on a decoded overdrive command byte
    a_r7_od_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overdrive) |-> $past(cmd_valid) &&
            ($past(cmd_byte) == OP_OD_SKIP || $past(cmd_byte) == OP_OD_MATCH));

    // R9: a dropped-out controller stays out until a bus reset
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCK && !bus_reset) |=> (st == ST_LOCK));

endmodule

// File: rtl/romfn_ctrl.sv
// Module: addressing controller top.
// Connects the command deserializer, the identity bit index and the sequencer,
// and selects the current identity bit. Assumes device_id is stable while the
// device is addressed, and that slots and bus resets arrive as one-cycle strobes.
module romfn_ctrl
    import romfn_pkg::*;
#(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_valid,
    input  logic            slot_bit,
    input  logic            bus_reset,
    input  logic            bus_reset_long,
    input  logic [ID_W-1:0] device_id,
    output logic            tx_bit,
    output logic            mem_enable,
    output logic            overdrive
);
    localparam int IW = $clog2(ID_W);

    logic             cmd_valid;
    logic [CMD_W-1:0] cmd_byte;
    logic             listen;
    logic             idx_clr;
    logic             idx_inc;
    logic [IW-1:0]    idx;
    logic             idx_last;
    logic             id_bit;
    seq_state_e       state;

    romfn_cmd_rx #(.CMD_W(CMD_W)) u_cmd_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (bus_reset),
        .listen     (listen),
        .slot_valid (slot_valid),
        .slot_bit   (slot_bit),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte)
    );

    romfn_bit_idx #(.N(ID_W)) u_bit_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idx_clr),
        .inc   (idx_inc),
        .idx   (idx),
        .last  (idx_last)
    );

    // Current identity bit selected by the shared index.
    always_comb id_bit = device_id[idx];

    romfn_seq_fsm #(.CMD_W(CMD_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_reset      (bus_reset),
        .bus_reset_long (bus_reset_long),
        .slot_valid     (slot_valid),
        .slot_bit       (slot_bit),
        .cmd_valid      (cmd_valid),
        .cmd_byte       (cmd_byte),
        .id_bit         (id_bit),
        .idx_last       (idx_last),
        .idx_clr        (idx_clr),
        .idx_inc        (idx_inc),
        .listen         (listen),
        .tx_bit         (tx_bit),
        .mem_enable     (mem_enable),
        .overdrive      (overdrive),
        .state          (state)
    );

    // R3: each read slot before the last moves to the next identity bit
    a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && slot_valid && !bus_reset && !idx_last)
            |=> (idx == $past(idx) + 1'b1));

    // R1: once addressed, the line is left released for the memory layer
    a_r1_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
        mem_enable |-> tx_bit);

    // R2: addressing is reached only via a decoded command or a finished slot
    a_r2_sel_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_enable) |-> $past(cmd_valid) || $past(slot_valid));

endmodule

// File: tb/romfn_ctrl_tb.sv
// Scoreboard bench: slot driver queues expected transmit levels, a monitor
// compares them in each checked slot; state checks run between commands.
module romfn_ctrl_tb;
    localparam int          ID_W = 64;
    localparam logic [63:0] ID   = 64'h7E5C3A9B1240F61D;

    typedef struct {
        logic  v;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_valid = 1'b0;
    logic slot_bit = 1'b0;
    logic bus_reset = 1'b0;
    logic bus_reset_long = 1'b0;
    logic chk_tx = 1'b0;
    logic tx_bit, mem_enable, overdrive;
    logic done = 1'b0;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    romfn_ctrl #(.ID_W(ID_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .slot_valid     (slot_valid),
        .slot_bit       (slot_bit),
        .bus_reset      (bus_reset),
        .bus_reset_long (bus_reset_long),
        .device_id      (ID),
        .tx_bit         (tx_bit),
        .mem_enable     (mem_enable),
        .overdrive      (overdrive)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: in each checked slot compare tx_bit against the queue head.
    always @(negedge clk) begin
        if (chk_tx) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: actual slot expected queued item");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, tx_bit, e.v);
            end
        end
    end

    // Driver: one slot, optionally queuing the expected transmit level.
    task automatic slot(input logic b, input logic chk, input logic e, input string tag);
        exp_t it;
        @(posedge clk); #1;
        if (chk) begin
            it.v = e; it.tag = tag;
            exp_q.push_back(it);
        end
        slot_valid = 1'b1; slot_bit = b; chk_tx = chk;
        @(posedge clk); #1;
        slot_valid = 1'b0; chk_tx = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) slot(b[i], 1'b0, 1'b0, "");
    endtask

    task automatic breset(input logic long_p);
        @(posedge clk); #1;
        bus_reset = 1'b1; bus_reset_long = long_p;
        @(posedge clk); #1;
        bus_reset = 1'b0; bus_reset_long = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic match_id(input logic [63:0] m, input string tag);
        for (int i = 0; i < 64; i++) slot(m[i], 1'b1, 1'b1, tag);
    endtask

    task automatic search(input logic [63:0] dir, input string tag);
        logic out;
        out = 1'b0;
        for (int i = 0; i < 64; i++) begin
            slot(1'b1, 1'b1, out ? 1'b1 : ID[i], tag);
            slot(1'b1, 1'b1, out ? 1'b1 : ~ID[i], tag);
            slot(dir[i], 1'b1, 1'b1, tag);
            if (dir[i] != ID[i]) out = 1'b1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 mem_enable", mem_enable, 1'b0);
        check("R1 overdrive", overdrive, 1'b0);
        check("R1 tx_bit", tx_bit, 1'b1);

        // R3 read identity
        breset(1'b1); send_byte(8'h33);
        for (int i = 0; i < 64; i++) slot(1'b1, 1'b1, ID[i], "R3 read bit");
        check("R3 mem_enable after read", mem_enable, 1'b1);

        // R6 skip
        breset(1'b1); send_byte(8'hCC);
        check("R6 mem_enable", mem_enable, 1'b1);
        check("R6 overdrive", overdrive, 1'b0);

        // R4 match ok, then mismatch in bit 63
        breset(1'b1); send_byte(8'h55); match_id(ID, "R4 match tx");
        check("R4 match ok", mem_enable, 1'b1);
        breset(1'b1); send_byte(8'h55);
        match_id(ID ^ 64'h8000_0000_0000_0000, "R4 match tx");
        check("R4 mismatch bit63", mem_enable, 1'b0);
        send_byte(8'hCC);
        check("R4 locked after mismatch", mem_enable, 1'b0);

        // R2 reversed bit order of the match code is not a match command
        breset(1'b1); send_byte(8'hAA); match_id(ID, "R2 tx");
        check("R2 reversed byte rejected", mem_enable, 1'b0);

        // R5 search full and with drop-out at bit 20
        breset(1'b1); send_byte(8'hF0); search(ID, "R5 search tx");
        check("R5 search win", mem_enable, 1'b1);
        breset(1'b1); send_byte(8'hF0); search(ID ^ (64'd1 << 20), "R5 search tx");
        check("R5 search dropout", mem_enable, 1'b0);

        // R9 unknown command
        breset(1'b1); send_byte(8'hA5);
        for (int i = 0; i < 4; i++) slot(1'b0, 1'b1, 1'b1, "R9 idle tx");
        send_byte(8'hCC);
        check("R9 ignores later skip", mem_enable, 1'b0);
        check("R9 overdrive", overdrive, 1'b0);

        // R10 reset mid-read
        breset(1'b1); send_byte(8'h33);
        for (int i = 0; i < 10; i++) slot(1'b1, 1'b1, ID[i], "R10 read bit");
        breset(1'b1);
        check("R10 mem_enable cleared", mem_enable, 1'b0);
        check("R10 tx released", tx_bit, 1'b1);
        send_byte(8'hCC);
        check("R10 command after reset", mem_enable, 1'b1);

        // R7 overdrive-skip and R10 overdrive exit rules
        breset(1'b1); send_byte(8'h3C);
        check("R7 overdrive", overdrive, 1'b1);
        check("R7 mem_enable", mem_enable, 1'b1);
        breset(1'b0);
        check("R10 short reset keeps overdrive", overdrive, 1'b1);
        check("R10 short reset clears mem", mem_enable, 1'b0);
        send_byte(8'hCC);
        check("R10 skip in overdrive", mem_enable, 1'b1);
        breset(1'b1);
        check("R10 long reset clears overdrive", overdrive, 1'b0);

        // R8 overdrive-match success and failure
        send_byte(8'h69);
        check("R8 overdrive after byte", overdrive, 1'b1);
        check("R8 not yet enabled", mem_enable, 1'b0);
        match_id(ID, "R8 match tx");
        check("R8 match ok", mem_enable, 1'b1);
        breset(1'b1); send_byte(8'h69);
        match_id(ID ^ 64'd1, "R8 match tx");
        check("R8 mismatch mem", mem_enable, 1'b0);
        check("R8 mismatch keeps overdrive", overdrive, 1'b1);

        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (R1..): actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule